// File: doc/BRIEF.md
# Startup Hold-Off Enable Generator

This block produces a synchronous run-enable for the critical state machines of a clock domain. When the asynchronous reset is released, flip-flops across the die can see the release on different clock edges. A machine that moves on the first edge can then land in a state it was never designed to reach. The generator keeps its run-enable low for a fixed number of clock cycles after the release, so every sensitive machine starts from its initial state on the same edge. Only those machines use the enable as their clock enable. The rest of the datapath runs freely.

An optional lock indication from the clock generator passes through a two-flop synchronizer. The enable stays low until lock is reported. A loss of lock, or a new reset, drops the enable and restarts the full hold-off. Some machines sit idle until an external event arrives. For these, a masked copy of the request bus is provided instead of a held machine: requests pass only while the enable is high.

The release register is a flop cleared asynchronously with its data input tied high. It feeds a second flop. Its output starts either a saturating counter or a shift chain, chosen by a parameter. Both give the same timing.

Top module: `boot_holdoff_gen`

## Requirements
- R1: While rst_ni is low, run_en_o is 0 and req_masked_o is all zeros, without waiting for a clock edge.
- R2: With lock_i held high, rst_ni released between two edges makes run_en_o rise exactly at the (HOLD_CYCLES+2)-th rising edge after the release (edge 17 with the default of 15). It stays low at every earlier edge.
- R3: Once high, run_en_o stays high for as long as rst_ni stays high and lock_i stays high.
- R4: run_en_o never rises while lock_i is low, however many cycles pass.
- R5: When lock_i falls between edges, run_en_o is still high after the second edge and low after the third. Even a one-cycle low pulse causes this. When lock_i returns high, run_en_o rises again at the (HOLD_CYCLES+2)-th edge after the return.
- R6: Asserting rst_ni drops run_en_o immediately, whether mid-count or after the enable is already high. The next release restarts the full delay of R2.
- R7: req_masked_o equals req_i in the same cycle while run_en_o is 1, and is all zeros while run_en_o is 0.
- R8: The shift-chain variant (CHAIN_STYLE = HOLD_SHIFT) drives run_en_o identically, cycle for cycle, to the counter variant (HOLD_COUNT, the default).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Domain clock |
| rst_ni | input | 1 | Asynchronous active-low reset; release may be asynchronous to clk_i |
| lock_i | input | 1 | Clock-generator lock indication, asynchronous, high when locked |
| req_i | input | REQ_W | Raw request events toward idle-waiting state machines |
| run_en_o | output | 1 | Run-enable for the clock enables of sensitive state machines |
| req_masked_o | output | REQ_W | req_i gated by run_en_o |

## Verification
The enable path has two synchronizer flops followed by one delay register stage. Its rise is therefore due HOLD_CYCLES+2 edges after a reset release or a lock return. A lock loss shows up on the third edge. A reset is seen at once, and the masked requests follow the enable combinationally. The bench changes its inputs 2 ns after a rising edge and reads the outputs at that same point. It counts edges from the first edge after a stimulus until the enable rises, and compares the count with the exact figure. The lock-loss check reads the enable after the second edge and again after the third. The reset and mask checks read 1 ns after the stimulus, with no edge in between.

// File: rtl/holdoff_pkg.sv
package holdoff_pkg;

  // Implementation of the hold-off delay line
  typedef enum logic {
    HOLD_COUNT = 1'b0,
    HOLD_SHIFT = 1'b1
  } hold_style_e;

  // Depth of the release register and of the lock synchronizer
  localparam int unsigned SYNC_STAGES = 2;

endpackage

// File: rtl/holdoff_rel_reg.sv
module holdoff_rel_reg #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rel_ok_o
);

  logic [STAGES-1:0] stage_q;
  logic [STAGES-1:0] stage_d;

  // First stage sees a constant one; later stages follow their predecessor
  always_comb begin
    stage_d[0] = 1'b1;
    for (int i = 1; i < STAGES; i++) begin
      stage_d[i] = stage_q[i-1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q <= '0;
    end else begin
      stage_q <= stage_d;
    end
  end

  assign rel_ok_o = stage_q[STAGES-1];

endmodule

// File: rtl/holdoff_lock_sync.sv
module holdoff_lock_sync #(
  parameter bit          USE_LOCK = 1'b1,
  parameter int unsigned STAGES   = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lock_i,
  output logic lock_ok_o
);

  generate
    if (USE_LOCK) begin : g_sync
      logic [STAGES-1:0] sync_q;
      logic [STAGES-1:0] sync_d;

      always_comb begin
        sync_d[0] = lock_i;
        for (int i = 1; i < STAGES; i++) begin
          sync_d[i] = sync_q[i-1];
        end
      end

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          sync_q <= '0;
        end else begin
          sync_q <= sync_d;
        end
      end

      assign lock_ok_o = sync_q[STAGES-1];
    end else begin : g_nolock
      logic unused_lock;
      logic unused_clk;
      logic unused_rst;
      assign unused_lock = lock_i;
      assign unused_clk  = clk_i;
      assign unused_rst  = rst_ni;
      assign lock_ok_o   = 1'b1;
    end
  endgenerate

endmodule

// File: rtl/holdoff_delay.sv
module holdoff_delay
  import holdoff_pkg::*;
#(
  parameter int unsigned HOLD_CYCLES = 15,
  parameter hold_style_e CHAIN_STYLE = HOLD_COUNT
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic run_en_o
);

  localparam int unsigned CNT_W = $clog2(HOLD_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_TOP  = CNT_W'(HOLD_CYCLES);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(HOLD_CYCLES - 1);

  generate
    if (CHAIN_STYLE == HOLD_COUNT) begin : g_count
      logic [CNT_W-1:0] cnt_q;
      logic [CNT_W-1:0] cnt_d;
      logic             en_q;
      logic             en_d;

      // Saturating count of edges with start held; any gap clears it
      always_comb begin
        if (!start_i) begin
          cnt_d = '0;
          en_d  = 1'b0;
        end else begin
          cnt_d = (cnt_q == CNT_TOP) ? cnt_q : cnt_q + 1'b1;
          en_d  = en_q | (cnt_q == CNT_LAST);
        end
      end

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          cnt_q <= '0;
          en_q  <= 1'b0;
        end else begin
          cnt_q <= cnt_d;
          en_q  <= en_d;
        end
      end

      assign run_en_o = en_q;
    end else begin : g_shift
      logic [HOLD_CYCLES-1:0] chain_q;
      logic [HOLD_CYCLES-1:0] chain_d;

      // Ones march in while start holds; any gap flushes the chain
      always_comb begin
        if (!start_i) begin
          chain_d = '0;
        end else begin
          chain_d = {chain_q[HOLD_CYCLES-2:0], 1'b1};
        end
      end

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          chain_q <= '0;
        end else begin
          chain_q <= chain_d;
        end
      end

      assign run_en_o = chain_q[HOLD_CYCLES-1];
    end
  endgenerate

endmodule

// File: rtl/boot_holdoff_gen.sv
module boot_holdoff_gen
  import holdoff_pkg::*;
#(
  parameter int unsigned HOLD_CYCLES = 15,
  parameter bit          USE_LOCK    = 1'b1,
  parameter hold_style_e CHAIN_STYLE = HOLD_COUNT,
  parameter int unsigned REQ_W       = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             lock_i,
  input  logic [REQ_W-1:0] req_i,
  output logic             run_en_o,
  output logic [REQ_W-1:0] req_masked_o
);

  logic rel_ok;
  logic lock_ok;
  logic start_ok;

  holdoff_rel_reg #(
    .STAGES (SYNC_STAGES)
  ) u_rel (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rel_ok_o (rel_ok)
  );

  holdoff_lock_sync #(
    .USE_LOCK (USE_LOCK),
    .STAGES   (SYNC_STAGES)
  ) u_lock (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .lock_i    (lock_i),
    .lock_ok_o (lock_ok)
  );

  assign start_ok = rel_ok & lock_ok;

  holdoff_delay #(
    .HOLD_CYCLES (HOLD_CYCLES),
    .CHAIN_STYLE (CHAIN_STYLE)
  ) u_delay (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_ok),
    .run_en_o (run_en_o)
  );

  assign req_masked_o = req_i & {REQ_W{run_en_o}};

endmodule

// File: rtl/boot_holdoff_gen_chk.sv
module boot_holdoff_gen_chk #(
  parameter int unsigned HOLD_CYCLES = 15
) (
  input logic clk_i,
  input logic rst_ni,
  input logic start_ok,
  input logic run_en_o
);

  localparam int unsigned WIN_W = $clog2(HOLD_CYCLES + 1);

  // Independent tally of consecutive edges with the start condition held
  logic [WIN_W-1:0] win_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win_q <= '0;
    end else if (!start_ok) begin
      win_q <= '0;
    end else if (win_q != WIN_W'(HOLD_CYCLES)) begin
      win_q <= win_q + 1'b1;
    end
  end

  AST_HOLD_EXACT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(run_en_o) |-> (win_q == WIN_W'(HOLD_CYCLES))); // R2

  AST_EN_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_en_o && start_ok) |=> run_en_o); // R3

  AST_NO_START_NO_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_ok |=> !run_en_o); // R4

  AST_FRESH_AFTER_RESET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> !run_en_o); // R6

endmodule

bind boot_holdoff_gen boot_holdoff_gen_chk #(
  .HOLD_CYCLES (HOLD_CYCLES)
) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .start_ok (start_ok),
  .run_en_o (run_en_o)
);

// File: tb/boot_holdoff_gen_test.sv
module boot_holdoff_gen_test;

  localparam int unsigned HOLD  = 15;
  localparam int unsigned REQ_W = 4;
  localparam int unsigned DUE   = HOLD + 2;

  logic             clk;
  logic             rst_n;
  logic             lock;
  logic [REQ_W-1:0] req;
  logic             run_en;
  logic [REQ_W-1:0] req_masked;
  logic             run_en_chain;
  logic [REQ_W-1:0] req_masked_chain;

  int checks_run  = 0;
  int checks_fail = 0;
  int chain_mism  = 0;

  boot_holdoff_gen #(
    .HOLD_CYCLES (HOLD),
    .USE_LOCK    (1'b1),
    .CHAIN_STYLE (holdoff_pkg::HOLD_COUNT),
    .REQ_W       (REQ_W)
  ) uut (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .lock_i       (lock),
    .req_i        (req),
    .run_en_o     (run_en),
    .req_masked_o (req_masked)
  );

  boot_holdoff_gen #(
    .HOLD_CYCLES (HOLD),
    .USE_LOCK    (1'b1),
    .CHAIN_STYLE (holdoff_pkg::HOLD_SHIFT),
    .REQ_W       (REQ_W)
  ) uut_chain (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .lock_i       (lock),
    .req_i        (req),
    .run_en_o     (run_en_chain),
    .req_masked_o (req_masked_chain)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks_run++;
    if (!ok) begin
      checks_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // One edge, then settle 2 ns past it; compare both variants (R8)
  task automatic step();
    @(posedge clk);
    #2;
    if (run_en !== run_en_chain) chain_mism++;
  endtask

  // Edges counted from the first one until run_en is seen high; masked bus checked meanwhile
  task automatic edges_to_rise(input int limit, output int n, output int leak);
    n = 0;
    leak = 0;
    do begin
      step();
      n++;
      if (!run_en && req_masked !== '0) leak++;
    end while (!run_en && n < limit);
  endtask

  task automatic t_reset_state();
    rst_n = 1'b0;
    lock  = 1'b1;
    req   = 4'hF;
    #1;
    check(run_en === 1'b0, "R1 run_en in reset", run_en, 0);
    check(req_masked === 4'h0, "R1 masked in reset", req_masked, 0);
    repeat (3) step();
    check(run_en === 1'b0 && req_masked === 4'h0, "R1 still clear after edges", run_en, 0);
  endtask

  task automatic t_first_release();
    int n;
    int leak;
    rst_n = 1'b1;
    edges_to_rise(DUE + 10, n, leak);
    check(n == DUE && run_en, "R2 rise edge after release", n, DUE);
    check(leak == 0, "R7 masked zero while held", leak, 0);
  endtask

  task automatic t_sticky();
    int drops = 0;
    for (int i = 0; i < 100; i++) begin
      step();
      if (!run_en) drops++;
    end
    check(drops == 0, "R3 enable stays high", drops, 0);
  endtask

  task automatic t_mask();
    logic [REQ_W-1:0] pats [4] = '{4'h0, 4'h5, 4'hA, 4'hF};
    for (int i = 0; i < 4; i++) begin
      req = pats[i];
      #1;
      check(req_masked === pats[i], "R7 masked passes when enabled", req_masked, pats[i]);
    end
    req = 4'hF;
  endtask

  task automatic t_lock_drop();
    int n;
    int leak;
    int rises = 0;
    lock = 1'b0;
    step();
    step();
    check(run_en === 1'b1, "R5 still high after second edge", run_en, 1);
    step();
    check(run_en === 1'b0, "R5 low after third edge", run_en, 0);
    check(req_masked === 4'h0, "R7 masked zero after lock loss", req_masked, 0);
    for (int i = 0; i < 60; i++) begin
      step();
      if (run_en) rises++;
    end
    check(rises == 0, "R4 no rise while unlocked", rises, 0);
    lock = 1'b1;
    edges_to_rise(DUE + 10, n, leak);
    check(n == DUE && run_en, "R5 rise edge after lock return", n, DUE);
  endtask

  task automatic t_lock_glitch();
    int n;
    int leak;
    lock = 1'b0;
    step();
    lock = 1'b1;
    step();
    check(run_en === 1'b1, "R5 glitch: high after second edge", run_en, 1);
    step();
    check(run_en === 1'b0, "R5 glitch: low after third edge", run_en, 0);
    edges_to_rise(DUE + 10, n, leak);
    check(n == DUE - 2 && run_en, "R5 glitch: restart length", n, DUE - 2);
  endtask

  task automatic t_boot_unlocked();
    int n;
    int leak;
    int rises = 0;
    rst_n = 1'b0;
    lock  = 1'b0;
    #1;
    check(run_en === 1'b0, "R6 reset drops enable at once", run_en, 0);
    repeat (3) step();
    rst_n = 1'b1;
    for (int i = 0; i < 80; i++) begin
      step();
      if (run_en) rises++;
    end
    check(rises == 0, "R4 boot without lock stays low", rises, 0);
    lock = 1'b1;
    edges_to_rise(DUE + 10, n, leak);
    check(n == DUE && run_en, "R4 rise once lock arrives", n, DUE);
  endtask

  task automatic t_reset_mid_count();
    int n;
    int leak;
    rst_n = 1'b0;
    repeat (3) step();
    rst_n = 1'b1;
    repeat (8) step();
    check(run_en === 1'b0, "R2 low mid count", run_en, 0);
    rst_n = 1'b0;
    #1;
    check(run_en === 1'b0 && req_masked === 4'h0, "R6 reset mid count", run_en, 0);
    repeat (2) step();
    rst_n = 1'b1;
    edges_to_rise(DUE + 10, n, leak);
    check(n == DUE && run_en, "R6 full delay after re-release", n, DUE);
    check(leak == 0, "R7 masked zero during restart", leak, 0);
  endtask

  initial begin
    #(200000 * 8);
    checks_run++;
    checks_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks_run, checks_fail);
    $finish;
  end

  initial begin
    t_reset_state();
    t_first_release();
    t_sticky();
    t_mask();
    t_lock_drop();
    t_lock_glitch();
    t_boot_unlocked();
    t_reset_mid_count();
    check(chain_mism == 0, "R8 shift chain matches counter", chain_mism, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks_run, checks_fail);
    $finish;
  end

endmodule